// File: doc/BRIEF.md
# Interrupt Controller Command Word Decoder

This block sits between the processor write port of an eight-input interrupt controller and the controller's priority logic. Every write carries one address bit and one data byte. The block works out which configuration or command word the byte is. It does this from three things: the address bit, two tag bits in the data, and how far a setup sequence has progressed. It then either updates a held register or raises a one-cycle command strobe.

A setup sequence always starts with a write to the even address that has data bit 4 set. This write is the leading setup word. It states whether the controller runs alone or in a cascade, and whether a final options word will follow. The words after it arrive on the odd address. They are, in order, the vector type base, the cascade word (only when not running alone), and the options word (only when it was requested). Once the sequence is over, odd writes load the interrupt mask. Even writes with data bit 4 clear are run-time commands. Data bit 3 then picks between the end-of-service / rotation command and the mode-control command.

The priority block takes the mask, the vector base and the auto end-of-service flag as held values. It takes the command strobes as pulses that last exactly one cycle. Each pulse carries its rotate, specific-level and level fields for that cycle only.

Top module: `cwd_write_decoder`

## Requirements
- R1: After reset, every output is zero: the mask, the vector base, all flags, all strobes and all command fields.
- R2: A write with addr0=0 and wdata[4]=1 is the leading setup word. In the next cycle init_stb is high for one cycle, the sequence is active, init_done=0, and the mask, auto_eoi, rot_aeoi, rd_isr and special_mask are all 0. The bits wdata[1] (1 = single, no cascade word) and wdata[0] (1 = options word follows) are captured, and single_mode becomes wdata[1].
- R3: The first odd write after the leading word sets vec_base to wdata[7:3].
- R4: When single_mode=0, the next odd write is taken as the cascade word and is discarded. When the options word was requested, the next odd write after that sets auto_eoi to wdata[1]. If it was not requested, auto_eoi stays 0. init_done becomes 1 in the cycle after the last expected word.
- R5: When no sequence is active, an odd write loads irq_mask with wdata. This also holds before any sequence has run.
- R6: An even write with wdata[4]=0, wdata[3]=0 and wdata[5]=1 raises eoi_stb for exactly one cycle. During that cycle cmd_rot=wdata[7], cmd_sl=wdata[6] and cmd_level=wdata[2:0]. cmd_rot, cmd_sl and cmd_level are 0 in every cycle where neither eoi_stb nor prio_stb is high.
- R7: For such a write with wdata[5]=0: R=1 and SL=1 raises prio_stb for one cycle, carrying the level. R=1 and SL=0 sets rot_aeoi. R=0 and SL=0 clears rot_aeoi. R=0 and SL=1 does nothing.
- R8: An even write with wdata[4]=0 and wdata[3]=1 is a mode-control word. If wdata[1]=1, rd_isr takes wdata[0]. If wdata[2]=1, poll_stb is raised for one cycle. If wdata[6]=1, special_mask takes wdata[5].
- R9: While a sequence is active, even writes with wdata[4]=0 have no effect on any output, and the mask holds its value.
- R10: A leading setup word that arrives in the middle of a sequence starts the sequence again from the type-base word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| addr0 | input | 1 | Address bit selecting the even (0) or odd (1) port |
| wdata | input | 8 | Write data byte |
| irq_mask | output | 8 | Interrupt mask, 1 blocks the input |
| vec_base | output | 5 | Upper vector bits from the type-base word |
| auto_eoi | output | 1 | Automatic end-of-service enabled |
| single_mode | output | 1 | Controller runs alone, no cascade |
| init_done | output | 1 | Setup sequence complete |
| init_stb | output | 1 | One-cycle pulse: sequence restarted, reset rotation |
| eoi_stb | output | 1 | One-cycle end-of-service command |
| prio_stb | output | 1 | One-cycle set-lowest-priority command |
| cmd_rot | output | 1 | Rotate field of the current command |
| cmd_sl | output | 1 | Specific-level field of the current command |
| cmd_level | output | 3 | Level field of the current command |
| rot_aeoi | output | 1 | Rotate on automatic end-of-service |
| rd_isr | output | 1 | Read select: 1 in-service, 0 request register |
| poll_stb | output | 1 | One-cycle poll command |
| special_mask | output | 1 | Special mask mode |

## Verification
The mask and the setup words share the odd address. The run-time commands and the leading setup word share the even address. For that reason the byte streams are built so that the same byte lands on the same address in different sequence positions: before setup, inside each sequence stage, and after it. Only the sequence position can then account for a difference in the outcome. Every combination of the R and SL bits is sent both with and without the end-of-service bit, and some of these go back to back, so that stale command fields or stretched strobes would show. The three sequence shapes are tried: options word only, cascade word with no options word, and a sequence restarted halfway through.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_TYPE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_OPT  = 2'd3
  } seq_e;

  typedef struct packed {
    logic lead;   // leading setup word on even port
    logic eor;    // end-of-service / rotation word
    logic mode;   // mode-control word
    logic odd;    // any odd-port write
  } wr_class_t;
endpackage

// File: rtl/cwd_classify.sv
module cwd_classify
  import cwd_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int TAG_BIT = 4,
  parameter int SEL_BIT = 3
) (
  input  logic              wr_en,
  input  logic              addr0,
  input  logic [DATA_W-1:0] wdata,
  output wr_class_t         cls
);
  logic even_wr;

  always_comb begin
    even_wr   = wr_en && !addr0;
    cls.lead  = even_wr && wdata[TAG_BIT];
    cls.eor   = even_wr && !wdata[TAG_BIT] && !wdata[SEL_BIT];
    cls.mode  = even_wr && !wdata[TAG_BIT] && wdata[SEL_BIT];
    cls.odd   = wr_en && addr0;
  end
endmodule

// File: rtl/cwd_init_seq.sv
module cwd_init_seq
  import cwd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3,
  localparam int VB_W  = DATA_W - LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_class_t         cls,
  input  logic [DATA_W-1:0] wdata,
  output logic              in_seq,
  output logic [VB_W-1:0]   vec_base,
  output logic              auto_eoi,
  output logic              single_mode,
  output logic              init_done,
  output logic              init_stb
);
  seq_e            state_q, state_d;
  logic            want_opt_q, want_opt_d;
  logic            single_d;
  logic            done_d;
  logic            aeoi_d;
  logic            vec_en;
  logic [VB_W-1:0] vec_d;

  assign in_seq = (state_q != SEQ_IDLE);

  // next state after the stage that just consumed an odd write
  always_comb begin
    state_d    = state_q;
    want_opt_d = want_opt_q;
    single_d   = single_mode;
    done_d     = init_done;
    aeoi_d     = auto_eoi;
    vec_en     = 1'b0;
    vec_d      = wdata[DATA_W-1:LVL_W];
    if (cls.lead) begin
      state_d    = SEQ_TYPE;
      want_opt_d = wdata[0];
      single_d   = wdata[1];
      done_d     = 1'b0;
      aeoi_d     = 1'b0;
    end else if (cls.odd) begin
      unique case (state_q)
        SEQ_TYPE: begin
          vec_en = 1'b1;
          if (!single_mode)    state_d = SEQ_CASC;
          else if (want_opt_q) state_d = SEQ_OPT;
          else begin
            state_d = SEQ_IDLE;
            done_d  = 1'b1;
          end
        end
        SEQ_CASC: begin
          if (want_opt_q) state_d = SEQ_OPT;
          else begin
            state_d = SEQ_IDLE;
            done_d  = 1'b1;
          end
        end
        SEQ_OPT: begin
          aeoi_d  = wdata[1];
          state_d = SEQ_IDLE;
          done_d  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SEQ_IDLE;
      want_opt_q  <= 1'b0;
      single_mode <= 1'b0;
      init_done   <= 1'b0;
      auto_eoi    <= 1'b0;
      init_stb    <= 1'b0;
    end else begin
      state_q     <= state_d;
      want_opt_q  <= want_opt_d;
      single_mode <= single_d;
      init_done   <= done_d;
      auto_eoi    <= aeoi_d;
      init_stb    <= cls.lead;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_base <= '0;
    else if (vec_en) vec_base <= vec_d;
  end

  assert_vec_only_type_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vec_base) |-> $past(state_q == SEQ_TYPE));

  assert_done_after_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(cls.odd));

  assert_restart_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_stb |-> (in_seq && !init_done && !auto_eoi));
endmodule

// File: rtl/cwd_op_regs.sv
module cwd_op_regs
  import cwd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_class_t         cls,
  input  logic              in_seq,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] irq_mask,
  output logic              eoi_stb,
  output logic              prio_stb,
  output logic              cmd_rot,
  output logic              cmd_sl,
  output logic [LVL_W-1:0]  cmd_level,
  output logic              rot_aeoi,
  output logic              rd_isr,
  output logic              poll_stb,
  output logic              special_mask
);
  localparam int EOI_BIT = 5;
  localparam int SL_BIT  = 6;
  localparam int R_BIT   = 7;

  logic              run_eor, run_mode;
  logic              mask_en;
  logic [DATA_W-1:0] mask_d;
  logic              eoi_d, prio_d, poll_d;
  logic              rot_d, sl_d;
  logic [LVL_W-1:0]  lvl_d;
  logic              raeoi_en, raeoi_d;
  logic              rd_en, smm_en;

  always_comb begin
    run_eor  = cls.eor && !in_seq;
    run_mode = cls.mode && !in_seq;

    mask_en  = cls.lead || (cls.odd && !in_seq);
    mask_d   = cls.lead ? '0 : wdata;

    eoi_d    = run_eor && wdata[EOI_BIT];
    prio_d   = run_eor && !wdata[EOI_BIT] && wdata[R_BIT] && wdata[SL_BIT];
    rot_d    = (eoi_d || prio_d) && wdata[R_BIT];
    sl_d     = (eoi_d || prio_d) && wdata[SL_BIT];
    lvl_d    = (eoi_d || prio_d) ? wdata[LVL_W-1:0] : '0;

    raeoi_en = cls.lead || (run_eor && !wdata[EOI_BIT] && !wdata[SL_BIT]);
    raeoi_d  = !cls.lead && wdata[R_BIT];

    rd_en    = cls.lead || (run_mode && wdata[1]);
    smm_en   = cls.lead || (run_mode && wdata[SL_BIT]);
    poll_d   = run_mode && wdata[2];
  end

  // pulse registers: dropped after one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoi_stb   <= 1'b0;
      prio_stb  <= 1'b0;
      cmd_rot   <= 1'b0;
      cmd_sl    <= 1'b0;
      cmd_level <= '0;
      poll_stb  <= 1'b0;
    end else begin
      eoi_stb   <= eoi_d;
      prio_stb  <= prio_d;
      cmd_rot   <= rot_d;
      cmd_sl    <= sl_d;
      cmd_level <= lvl_d;
      poll_stb  <= poll_d;
    end
  end

  // held registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_mask     <= '0;
      rot_aeoi     <= 1'b0;
      rd_isr       <= 1'b0;
      special_mask <= 1'b0;
    end else begin
      if (mask_en)  irq_mask     <= mask_d;
      if (raeoi_en) rot_aeoi     <= raeoi_d;
      if (rd_en)    rd_isr       <= !cls.lead && wdata[0];
      if (smm_en)   special_mask <= !cls.lead && wdata[EOI_BIT];
    end
  end

  assert_mask_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cls.lead |=> (irq_mask == '0));

  assert_mask_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_seq && !cls.lead) |=> $stable(irq_mask));

  assert_fields_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(eoi_stb || prio_stb) |-> (!cmd_rot && !cmd_sl && cmd_level == '0));

  assert_no_cmd_in_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_seq && !cls.lead) |=> (!eoi_stb && !prio_stb && !poll_stb));

  assert_prio_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prio_stb |-> (cmd_rot && cmd_sl && !eoi_stb));
endmodule

// File: rtl/cwd_write_decoder.sv
module cwd_write_decoder
  import cwd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3,
  localparam int VB_W  = DATA_W - LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr0,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] irq_mask,
  output logic [VB_W-1:0]   vec_base,
  output logic              auto_eoi,
  output logic              single_mode,
  output logic              init_done,
  output logic              init_stb,
  output logic              eoi_stb,
  output logic              prio_stb,
  output logic              cmd_rot,
  output logic              cmd_sl,
  output logic [LVL_W-1:0]  cmd_level,
  output logic              rot_aeoi,
  output logic              rd_isr,
  output logic              poll_stb,
  output logic              special_mask
);
  wr_class_t cls;
  logic      in_seq;

  cwd_classify #(.DATA_W(DATA_W)) u_classify (
    .wr_en (wr_en),
    .addr0 (addr0),
    .wdata (wdata),
    .cls   (cls)
  );

  cwd_init_seq #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_init_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cls         (cls),
    .wdata       (wdata),
    .in_seq      (in_seq),
    .vec_base    (vec_base),
    .auto_eoi    (auto_eoi),
    .single_mode (single_mode),
    .init_done   (init_done),
    .init_stb    (init_stb)
  );

  cwd_op_regs #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_op_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cls          (cls),
    .in_seq       (in_seq),
    .wdata        (wdata),
    .irq_mask     (irq_mask),
    .eoi_stb      (eoi_stb),
    .prio_stb     (prio_stb),
    .cmd_rot      (cmd_rot),
    .cmd_sl       (cmd_sl),
    .cmd_level    (cmd_level),
    .rot_aeoi     (rot_aeoi),
    .rd_isr       (rd_isr),
    .poll_stb     (poll_stb),
    .special_mask (special_mask)
  );

  assert_odd_loads_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr0 && !in_seq) |=> (irq_mask == $past(wdata)));

  assert_one_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cls.lead, cls.eor, cls.mode, cls.odd}));
endmodule

// File: tb/test_cwd_write_decoder.sv
module test_cwd_write_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr0 = 1'b0;
  logic [7:0] wdata = 8'h00;

  logic [7:0] irq_mask;
  logic [4:0] vec_base;
  logic       auto_eoi, single_mode, init_done, init_stb;
  logic       eoi_stb, prio_stb, cmd_rot, cmd_sl;
  logic [2:0] cmd_level;
  logic       rot_aeoi, rd_isr, poll_stb, special_mask;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cwd_write_decoder i_cwd_write_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr0(addr0), .wdata(wdata),
    .irq_mask(irq_mask), .vec_base(vec_base), .auto_eoi(auto_eoi),
    .single_mode(single_mode), .init_done(init_done), .init_stb(init_stb),
    .eoi_stb(eoi_stb), .prio_stb(prio_stb), .cmd_rot(cmd_rot), .cmd_sl(cmd_sl),
    .cmd_level(cmd_level), .rot_aeoi(rot_aeoi), .rd_isr(rd_isr),
    .poll_stb(poll_stb), .special_mask(special_mask)
  );

  // behavioural reference: stage 0 idle, 1 type, 2 cascade, 3 options
  int   m_stage;
  bit   m_want_opt, m_single, m_done, m_aeoi, m_istb;
  int   m_mask, m_vec;
  bit   m_eoi, m_prio, m_rot, m_sl, m_poll, m_raeoi, m_rd, m_smm;
  int   m_lvl;

  always @(posedge clk) begin
    m_eoi = 0; m_prio = 0; m_rot = 0; m_sl = 0; m_lvl = 0; m_poll = 0; m_istb = 0;
    if (!rst_n) begin
      m_stage = 0; m_want_opt = 0; m_single = 0; m_done = 0; m_aeoi = 0;
      m_mask = 0; m_vec = 0; m_raeoi = 0; m_rd = 0; m_smm = 0;
    end else if (wr_en) begin
      if (!addr0 && wdata[4]) begin
        m_stage = 1; m_want_opt = wdata[0]; m_single = wdata[1];
        m_done = 0; m_aeoi = 0; m_mask = 0; m_raeoi = 0; m_rd = 0; m_smm = 0;
        m_istb = 1;
      end else if (addr0) begin
        if (m_stage == 0) m_mask = wdata;
        else if (m_stage == 1) begin
          m_vec = wdata >> 3;
          m_stage = !m_single ? 2 : (m_want_opt ? 3 : 0);
          if (m_stage == 0) m_done = 1;
        end else if (m_stage == 2) begin
          m_stage = m_want_opt ? 3 : 0;
          if (m_stage == 0) m_done = 1;
        end else begin
          m_aeoi = wdata[1]; m_stage = 0; m_done = 1;
        end
      end else if (m_stage == 0) begin
        if (!wdata[3]) begin
          if (wdata[5]) begin
            m_eoi = 1; m_rot = wdata[7]; m_sl = wdata[6]; m_lvl = wdata[2:0];
          end else if (wdata[7] && wdata[6]) begin
            m_prio = 1; m_rot = 1; m_sl = 1; m_lvl = wdata[2:0];
          end else if (!wdata[6]) m_raeoi = wdata[7];
        end else begin
          if (wdata[1]) m_rd = wdata[0];
          if (wdata[2]) m_poll = 1;
          if (wdata[6]) m_smm = wdata[5];
        end
      end
    end
  end

  task automatic cmp(string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cmp("irq_mask", irq_mask, m_mask);
      cmp("vec_base", vec_base, m_vec);
      cmp("auto_eoi", auto_eoi, m_aeoi);
      cmp("single_mode", single_mode, m_single);
      cmp("init_done", init_done, m_done);
      cmp("init_stb", init_stb, m_istb);
      cmp("eoi_stb", eoi_stb, m_eoi);
      cmp("prio_stb", prio_stb, m_prio);
      cmp("cmd_rot", cmd_rot, m_rot);
      cmp("cmd_sl", cmd_sl, m_sl);
      cmp("cmd_level", cmd_level, m_lvl);
      cmp("rot_aeoi", rot_aeoi, m_raeoi);
      cmp("rd_isr", rd_isr, m_rd);
      cmp("poll_stb", poll_stb, m_poll);
      cmp("special_mask", special_mask, m_smm);
    end
  end

  // inputs change on the falling edge only
  task automatic wr(bit a, logic [7:0] d);
    wr_en = 1'b1; addr0 = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr0 = 1'b0; wdata = 8'h00;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; idle(2);

    cur_req = "R5"; wr(1, 8'hA5); idle(1);

    cur_req = "R2"; wr(0, 8'h13); idle(1);
    cur_req = "R9"; wr(0, 8'h20); wr(0, 8'h0C); wr(0, 8'h80); idle(1);
    cur_req = "R3"; wr(1, 8'h48); idle(1);
    cur_req = "R4"; wr(1, 8'h03); idle(1);
    cur_req = "R5"; wr(1, 8'h3C); idle(1);

    cur_req = "R6"; wr(0, 8'h20); idle(1); wr(0, 8'h63); wr(0, 8'hA0); wr(0, 8'hE5); idle(2);
    cur_req = "R7"; wr(0, 8'hC6); idle(1); wr(0, 8'h80); idle(1); wr(0, 8'h44); idle(1);
    wr(0, 8'h00); idle(1); wr(0, 8'hC1); wr(0, 8'h27); idle(1);
    cur_req = "R8"; wr(0, 8'h0B); wr(0, 8'h0C); wr(0, 8'h68); idle(1);
    wr(0, 8'h48); wr(0, 8'h0A); wr(0, 8'h09); idle(1);

    cur_req = "R2"; wr(0, 8'h6B); wr(0, 8'h80); wr(0, 8'h10); idle(1);
    cur_req = "R4"; wr(1, 8'h20); wr(1, 8'h04); idle(1); wr(1, 8'hFF); idle(1);

    cur_req = "R10"; wr(0, 8'h11); wr(1, 8'hF8); idle(1); wr(0, 8'h12); idle(1);
    wr(1, 8'h10); idle(1); wr(1, 8'h02); idle(1); wr(1, 8'h81); idle(1);
    wr(0, 8'h1F); wr(1, 8'h08); wr(1, 8'h55); wr(1, 8'h00); idle(1); wr(1, 8'h66); idle(2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule